// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block produces the serial clock waveform for an I2C master. Software programs a high count and a low count for each of three speed classes (standard, fast and high speed), a spike-suppression length for the high-speed class and a second one shared by the two slower classes, and an SDA hold count. A two-bit speed field picks which count pair and which spike length are used. All counts are in controller clock cycles.

While the run enable is high, the generator alternates a low phase and a high phase on its SCL drive output. It marks the first cycle of each phase with a one-cycle strobe. During every low phase it pulses a data-change strobe once the SDA hold time has elapsed after the SCL falling edge. The surrounding master uses that pulse as the earliest point at which it may move SDA. The selected configuration is captured when the generator starts. It stays frozen until the run enable is dropped and raised again, so a reprogramming can never produce a truncated or stretched phase.

Top module: `scl_timing_gen`

## Requirements
- R1: While reset is high or run_en is low, scl_o is 1 (released) and low_start, high_start and sda_change are 0. Dropping run_en in any phase releases scl_o from the next clock cycle on.
- R2: The cycle after run_en is first sampled high is the first cycle of a low phase: scl_o is 0 and low_start is 1 in that cycle.
- R3: Each low phase lasts the effective low count + 1 cycles. Low and high phases alternate, and every low phase of a run has the same length.
- R4: Each high phase lasts the effective high count + spike length + 7 cycles, and high_start is 1 in exactly its first cycle.
- R5: speed_sel encodes 1 = standard pair, 2 = fast pair (also used for fast-plus), 3 = high-speed pair. The value 0 selects the standard pair.
- R6: With speed_sel = 3 the high phase adds spk_len_hs. With every other code it adds spk_len_fs.
- R7: A high count, low count or hold count of zero acts as 1, so no phase or hold collapses to zero length.
- R8: In each low phase sda_change is 1 in exactly one cycle. When the effective hold H is smaller than the low length L, that cycle is H cycles after the first low cycle (offset 0 being the first low cycle).
- R9: When H is L or more, sda_change fires in the last cycle of the low phase (offset L-1).
- R10: Counts, spike lengths, speed select and hold count are captured in the cycle in which run_en starts a run. Changes made while running have no effect until run_en is dropped and raised again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Run enable; high generates SCL, low releases it |
| speed_sel | input | 2 | Speed class select: 1 standard, 2 fast, 3 high speed, 0 standard |
| std_hcnt | input | CNT_W | Standard-speed high count |
| std_lcnt | input | CNT_W | Standard-speed low count |
| fast_hcnt | input | CNT_W | Fast-speed high count |
| fast_lcnt | input | CNT_W | Fast-speed low count |
| hs_hcnt | input | CNT_W | High-speed high count |
| hs_lcnt | input | CNT_W | High-speed low count |
| spk_len_fs | input | SPK_W | Spike-suppression length for standard and fast classes |
| spk_len_hs | input | SPK_W | Spike-suppression length for the high-speed class |
| sda_hold_cnt | input | HOLD_W | SDA hold count after the SCL falling edge |
| scl_o | output | 1 | SCL drive: 0 pulls low, 1 releases |
| low_start | output | 1 | One-cycle strobe in the first cycle of each low phase |
| high_start | output | 1 | One-cycle strobe in the first cycle of each high phase |
| sda_change | output | 1 | One-cycle strobe when SDA may change within a low phase |

## Verification
The bench builds the generator with CNT_W = 8, SPK_W = 4 and HOLD_W = 8. With these widths the largest counts and spike lengths can be programmed, which gives a 277-cycle high phase and a 256-cycle low phase, and each such case stays short to run. The narrow hold field can still exceed short low phases, so the clamp to the last low cycle and the hold-of-zero case are both reachable next to the all-maximum case. The non-selected count pairs are loaded with decoy values, so a wrong pair or spike choice shows up as a wrong phase length.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;

    localparam logic [1:0] SEL_STD  = 2'd1;
    localparam logic [1:0] SEL_FAST = 2'd2;
    localparam logic [1:0] SEL_HS   = 2'd3;

    localparam int NUM_PAIRS        = 3;
    localparam int FIXED_HIGH_EXTRA = 7;
    localparam int LOW_EXTRA        = 1;

    // Index of the count pair used by a speed code: 0 std, 1 fast, 2 high speed
    function automatic logic [1:0] pair_of(input logic [1:0] sel);
        case (sel)
            SEL_FAST: return 2'd1;
            SEL_HS:   return 2'd2;
            default:  return 2'd0;
        endcase
    endfunction

    function automatic logic uses_hs_spike(input logic [1:0] sel);
        return sel == SEL_HS;
    endfunction

endpackage

// File: rtl/scl_cfg_latch.sv
module scl_cfg_latch
    import scl_timing_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int SPK_W  = 8,
    parameter int HOLD_W = 16,
    parameter int LEN_W  = 18
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               capture,
    input  logic [1:0]                         speed_sel,
    input  logic [NUM_PAIRS-1:0][CNT_W-1:0]    hcnt_pairs,
    input  logic [NUM_PAIRS-1:0][CNT_W-1:0]    lcnt_pairs,
    input  logic [SPK_W-1:0]                   spk_fs,
    input  logic [SPK_W-1:0]                   spk_hs,
    input  logic [HOLD_W-1:0]                  hold_cnt,
    output logic [LEN_W-1:0]                   nxt_low_len,
    output logic [LEN_W-1:0]                   nxt_high_len,
    output logic [HOLD_W-1:0]                  nxt_hold,
    output logic [LEN_W-1:0]                   cur_low_len,
    output logic [LEN_W-1:0]                   cur_high_len,
    output logic [HOLD_W-1:0]                  cur_hold
);

    logic [CNT_W-1:0] h_eff [NUM_PAIRS];
    logic [CNT_W-1:0] l_eff [NUM_PAIRS];
    logic [CNT_W-1:0] h_sel;
    logic [CNT_W-1:0] l_sel;
    logic [SPK_W-1:0] spk_sel;
    logic [1:0]       idx;

    // Zero counts are promoted to the minimum legal value of 1
    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        assign h_eff[p] = (hcnt_pairs[p] == '0) ? CNT_W'(1) : hcnt_pairs[p];
        assign l_eff[p] = (lcnt_pairs[p] == '0) ? CNT_W'(1) : lcnt_pairs[p];
    end

    always_comb begin
        idx     = pair_of(speed_sel);
        spk_sel = uses_hs_spike(speed_sel) ? spk_hs : spk_fs;
        case (idx)
            2'd1:    begin h_sel = h_eff[1]; l_sel = l_eff[1]; end
            2'd2:    begin h_sel = h_eff[2]; l_sel = l_eff[2]; end
            default: begin h_sel = h_eff[0]; l_sel = l_eff[0]; end
        endcase
        nxt_high_len = LEN_W'(h_sel) + LEN_W'(spk_sel) + LEN_W'(FIXED_HIGH_EXTRA);
        nxt_low_len  = LEN_W'(l_sel) + LEN_W'(LOW_EXTRA);
        nxt_hold     = (hold_cnt == '0) ? HOLD_W'(1) : hold_cnt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_low_len  <= '0;
            cur_high_len <= '0;
            cur_hold     <= '0;
        end else if (capture) begin
            cur_low_len  <= nxt_low_len;
            cur_high_len <= nxt_high_len;
            cur_hold     <= nxt_hold;
        end
    end

    assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (rst)
        !capture |=> ($stable(cur_low_len) && $stable(cur_high_len) && $stable(cur_hold)));

endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq
    import scl_timing_pkg::*;
#(
    parameter int LEN_W = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  logic [LEN_W-1:0] nxt_low_len,
    input  logic [LEN_W-1:0] cur_low_len,
    input  logic [LEN_W-1:0] cur_high_len,
    output logic             capture,
    output logic             low_load,
    output phase_e           phase,
    output logic             near_end,
    output logic             low_start,
    output logic             high_start
);

    logic [LEN_W-1:0] ph_cnt;

    assign capture  = run_en && (phase == PH_IDLE);
    assign low_load = run_en && (capture || (phase == PH_HIGH && ph_cnt == '0));
    assign near_end = (phase == PH_LOW) && (ph_cnt == LEN_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_IDLE;
            ph_cnt     <= '0;
            low_start  <= 1'b0;
            high_start <= 1'b0;
        end else begin
            low_start  <= 1'b0;
            high_start <= 1'b0;
            if (!run_en) begin
                phase  <= PH_IDLE;
                ph_cnt <= '0;
            end else begin
                case (phase)
                    PH_IDLE: begin
                        phase     <= PH_LOW;
                        ph_cnt    <= nxt_low_len - 1'b1;
                        low_start <= 1'b1;
                    end
                    PH_LOW: begin
                        if (ph_cnt == '0) begin
                            phase      <= PH_HIGH;
                            ph_cnt     <= cur_high_len - 1'b1;
                            high_start <= 1'b1;
                        end else begin
                            ph_cnt <= ph_cnt - 1'b1;
                        end
                    end
                    PH_HIGH: begin
                        if (ph_cnt == '0) begin
                            phase     <= PH_LOW;
                            ph_cnt    <= cur_low_len - 1'b1;
                            low_start <= 1'b1;
                        end else begin
                            ph_cnt <= ph_cnt - 1'b1;
                        end
                    end
                    default: begin
                        phase  <= PH_IDLE;
                        ph_cnt <= '0;
                    end
                endcase
            end
        end
    end

    assert_start_low_R2: assert property (@(posedge clk) disable iff (rst)
        capture |=> (phase == PH_LOW && low_start));

    assert_low_bound_R3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_LOW) |-> (ph_cnt < cur_low_len));

    assert_high_bound_R4: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_HIGH) |-> (ph_cnt < cur_high_len));

endmodule

// File: rtl/scl_sda_hold.sv
module scl_sda_hold #(
    parameter int HOLD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_en,
    input  logic              low_load,
    input  logic [HOLD_W-1:0] hold_val,
    input  logic              in_low,
    input  logic              near_end,
    output logic              sda_change
);

    logic [HOLD_W-1:0] hold_q;
    logic              fired;

    always_ff @(posedge clk) begin
        if (rst || !run_en) begin
            hold_q     <= '0;
            fired      <= 1'b1;
            sda_change <= 1'b0;
        end else if (low_load) begin
            hold_q     <= hold_val;
            fired      <= 1'b0;
            sda_change <= 1'b0;
        end else if (in_low && !fired) begin
            if (hold_q != '0) begin
                hold_q <= hold_q - 1'b1;
            end
            // Fire when the hold elapses, or at the latest in the last low cycle
            if (hold_q == HOLD_W'(1) || near_end) begin
                sda_change <= 1'b1;
                fired      <= 1'b1;
            end else begin
                sda_change <= 1'b0;
            end
        end else begin
            sda_change <= 1'b0;
        end
    end

    assert_sda_in_low_R8: assert property (@(posedge clk) disable iff (rst)
        sda_change |-> in_low);

    assert_sda_single_R8: assert property (@(posedge clk) disable iff (rst)
        sda_change |=> !sda_change);

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
    import scl_timing_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int SPK_W  = 8,
    parameter int HOLD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_en,
    input  logic [1:0]        speed_sel,
    input  logic [CNT_W-1:0]  std_hcnt,
    input  logic [CNT_W-1:0]  std_lcnt,
    input  logic [CNT_W-1:0]  fast_hcnt,
    input  logic [CNT_W-1:0]  fast_lcnt,
    input  logic [CNT_W-1:0]  hs_hcnt,
    input  logic [CNT_W-1:0]  hs_lcnt,
    input  logic [SPK_W-1:0]  spk_len_fs,
    input  logic [SPK_W-1:0]  spk_len_hs,
    input  logic [HOLD_W-1:0] sda_hold_cnt,
    output logic              scl_o,
    output logic              low_start,
    output logic              high_start,
    output logic              sda_change
);

    localparam int WIDEST = (CNT_W > SPK_W) ? CNT_W : SPK_W;
    localparam int LEN_W  = WIDEST + 2;

    logic [NUM_PAIRS-1:0][CNT_W-1:0] hcnt_pairs;
    logic [NUM_PAIRS-1:0][CNT_W-1:0] lcnt_pairs;
    logic [LEN_W-1:0]  nxt_low_len, nxt_high_len, cur_low_len, cur_high_len;
    logic [HOLD_W-1:0] nxt_hold, cur_hold, hold_val;
    logic              capture, low_load, near_end;
    phase_e            phase;

    assign hcnt_pairs = {hs_hcnt, fast_hcnt, std_hcnt};
    assign lcnt_pairs = {hs_lcnt, fast_lcnt, std_lcnt};

    scl_cfg_latch #(
        .CNT_W (CNT_W),
        .SPK_W (SPK_W),
        .HOLD_W(HOLD_W),
        .LEN_W (LEN_W)
    ) cfg_i (
        .clk         (clk),
        .rst         (rst),
        .capture     (capture),
        .speed_sel   (speed_sel),
        .hcnt_pairs  (hcnt_pairs),
        .lcnt_pairs  (lcnt_pairs),
        .spk_fs      (spk_len_fs),
        .spk_hs      (spk_len_hs),
        .hold_cnt    (sda_hold_cnt),
        .nxt_low_len (nxt_low_len),
        .nxt_high_len(nxt_high_len),
        .nxt_hold    (nxt_hold),
        .cur_low_len (cur_low_len),
        .cur_high_len(cur_high_len),
        .cur_hold    (cur_hold)
    );

    scl_phase_seq #(
        .LEN_W(LEN_W)
    ) seq_i (
        .clk         (clk),
        .rst         (rst),
        .run_en      (run_en),
        .nxt_low_len (nxt_low_len),
        .cur_low_len (cur_low_len),
        .cur_high_len(cur_high_len),
        .capture     (capture),
        .low_load    (low_load),
        .phase       (phase),
        .near_end    (near_end),
        .low_start   (low_start),
        .high_start  (high_start)
    );

    assign hold_val = capture ? nxt_hold : cur_hold;

    scl_sda_hold #(
        .HOLD_W(HOLD_W)
    ) hold_i (
        .clk       (clk),
        .rst       (rst),
        .run_en    (run_en),
        .low_load  (low_load),
        .hold_val  (hold_val),
        .in_low    (phase == PH_LOW),
        .near_end  (near_end),
        .sda_change(sda_change)
    );

    assign scl_o = (phase != PH_LOW);

    assert_idle_release_R1: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> (scl_o && !low_start && !high_start && !sda_change));

    assert_low_mark_R2: assert property (@(posedge clk) disable iff (rst)
        low_start |-> !scl_o);

    assert_high_mark_R4: assert property (@(posedge clk) disable iff (rst)
        high_start |-> scl_o);

endmodule

// File: tb/scl_timing_gen_tb_top.sv
module scl_timing_gen_tb_top;

    localparam int CNT_W  = 8;
    localparam int SPK_W  = 4;
    localparam int HOLD_W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic run_en = 1'b0;
    logic [1:0] speed_sel = 2'd1;
    logic [CNT_W-1:0] std_hcnt = '0, std_lcnt = '0, fast_hcnt = '0;
    logic [CNT_W-1:0] fast_lcnt = '0, hs_hcnt = '0, hs_lcnt = '0;
    logic [SPK_W-1:0] spk_len_fs = '0, spk_len_hs = '0;
    logic [HOLD_W-1:0] sda_hold_cnt = '0;
    logic scl_o, low_start, high_start, sda_change;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    scl_timing_gen #(
        .CNT_W (CNT_W),
        .SPK_W (SPK_W),
        .HOLD_W(HOLD_W)
    ) dut_i (
        .clk         (clk),
        .rst         (rst),
        .run_en      (run_en),
        .speed_sel   (speed_sel),
        .std_hcnt    (std_hcnt),
        .std_lcnt    (std_lcnt),
        .fast_hcnt   (fast_hcnt),
        .fast_lcnt   (fast_lcnt),
        .hs_hcnt     (hs_hcnt),
        .hs_lcnt     (hs_lcnt),
        .spk_len_fs  (spk_len_fs),
        .spk_len_hs  (spk_len_hs),
        .sda_hold_cnt(sda_hold_cnt),
        .scl_o       (scl_o),
        .low_start   (low_start),
        .high_start  (high_start),
        .sda_change  (sda_change)
    );

    typedef struct packed {
        logic [1:0] spd;
        logic [7:0] h;
        logic [7:0] l;
        logic [3:0] sf;
        logic [3:0] sh;
        logic [7:0] hold;
        logic [9:0] e_lo;
        logic [9:0] e_hi;
        logic [9:0] e_sda;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 8'd10,  8'd12,  4'd3,  4'd5,  8'd4,   10'd13,  10'd20,  10'd4},   // R5 standard
        '{2'd2, 8'd5,   8'd8,   4'd2,  4'd9,  8'd3,   10'd9,   10'd14,  10'd3},   // R5 fast, R6 fs spike
        '{2'd3, 8'd4,   8'd6,   4'd2,  4'd9,  8'd2,   10'd7,   10'd20,  10'd2},   // R6 hs spike
        '{2'd1, 8'd0,   8'd0,   4'd0,  4'd0,  8'd0,   10'd2,   10'd8,   10'd1},   // R7 zero counts
        '{2'd2, 8'd1,   8'd3,   4'd0,  4'd0,  8'd50,  10'd4,   10'd8,   10'd3},   // R9 hold clamp
        '{2'd0, 8'd6,   8'd7,   4'd1,  4'd4,  8'd5,   10'd8,   10'd14,  10'd5},   // R5 code 0 -> standard
        '{2'd3, 8'd255, 8'd255, 4'd15, 4'd15, 8'd255, 10'd256, 10'd277, 10'd255}, // maximum counts
        '{2'd2, 8'd20,  8'd30,  4'd15, 4'd1,  8'd31,  10'd31,  10'd42,  10'd30}   // R9 hold = L
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        std_hcnt  = 8'd200; std_lcnt  = 8'd200;
        fast_hcnt = 8'd200; fast_lcnt = 8'd200;
        hs_hcnt   = 8'd200; hs_lcnt   = 8'd200;
        case (v.spd)
            2'd2:    begin fast_hcnt = v.h; fast_lcnt = v.l; end
            2'd3:    begin hs_hcnt = v.h; hs_lcnt = v.l; end
            default: begin std_hcnt = v.h; std_lcnt = v.l; end
        endcase
        speed_sel    = v.spd;
        spk_len_fs   = v.sf;
        spk_len_hs   = v.sh;
        sda_hold_cnt = v.hold;
    endtask

    // Called at the negedge where run_en was just raised
    task automatic measure(output int lo, output int hi, output int sn, output int sc,
                           output int lo2, output bit ls, output bit hsb);
        @(negedge clk);
        ls = (scl_o == 1'b0) && low_start;
        lo = 0; sn = -1; sc = 0;
        while (scl_o == 1'b0 && lo < 4000) begin
            if (sda_change) begin
                sc++;
                if (sn < 0) sn = lo;
            end
            lo++;
            @(negedge clk);
        end
        hsb = high_start;
        hi = 0;
        while (scl_o == 1'b1 && hi < 4000) begin
            hi++;
            @(negedge clk);
        end
        lo2 = 0;
        while (scl_o == 1'b0 && lo2 < 4000) begin
            lo2++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int lo, hi, sn, sc, lo2, n, bad;
        bit ls, hsb;

        repeat (3) @(negedge clk);
        // R1 reset state
        check(scl_o == 1'b1, "R1 scl released in reset", int'(scl_o), 1);
        check(!low_start && !high_start && !sda_change, "R1 strobes quiet in reset",
              int'({low_start, high_start, sda_change}), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check(scl_o == 1'b1, "R1 scl released while run_en low", int'(scl_o), 1);

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i]);
            run_en = 1'b1;
            measure(lo, hi, sn, sc, lo2, ls, hsb);
            check(ls, $sformatf("R2 low start vec%0d", i), int'(ls), 1);
            check(lo == int'(VECS[i].e_lo), $sformatf("R3/R5/R7 low len vec%0d", i), lo, int'(VECS[i].e_lo));
            check(hi == int'(VECS[i].e_hi), $sformatf("R4/R5/R6 high len vec%0d", i), hi, int'(VECS[i].e_hi));
            check(hsb, $sformatf("R4 high strobe vec%0d", i), int'(hsb), 1);
            check(lo2 == int'(VECS[i].e_lo), $sformatf("R3 second low len vec%0d", i), lo2, int'(VECS[i].e_lo));
            check(sn == int'(VECS[i].e_sda), $sformatf("R8/R9 sda offset vec%0d", i), sn, int'(VECS[i].e_sda));
            check(sc == 1, $sformatf("R8 sda strobe count vec%0d", i), sc, 1);
            run_en = 1'b0;
            @(negedge clk);
            check(scl_o == 1'b1, $sformatf("R1 release after run vec%0d", i), int'(scl_o), 1);
            @(negedge clk);
        end

        // R10: change while running is ignored
        apply(VECS[0]);
        run_en = 1'b1;
        @(negedge clk);
        std_lcnt = 8'd40;
        n = 0;
        while (scl_o == 1'b0 && n < 4000) begin n++; @(negedge clk); end
        while (scl_o == 1'b1 && n < 8000) begin n++; @(negedge clk); end
        lo = 0;
        while (scl_o == 1'b0 && lo < 4000) begin lo++; @(negedge clk); end
        check(lo == 13, "R10 low len frozen while running", lo, 13);
        // R1: drop run_en during a high phase
        run_en = 1'b0;
        bad = 0;
        repeat (4) begin
            @(negedge clk);
            if (!scl_o || low_start || high_start || sda_change) bad++;
        end
        check(bad == 0, "R1 idle quiet after drop in high", bad, 0);
        // R10: new value used after re-enable
        run_en = 1'b1;
        measure(lo, hi, sn, sc, lo2, ls, hsb);
        check(lo == 41, "R10 new low len after re-enable", lo, 41);
        run_en = 1'b0;
        @(negedge clk);

        // R1: drop run_en in the middle of a low phase
        run_en = 1'b1;
        @(negedge clk);
        check(scl_o == 1'b0, "R2 low phase begins", int'(scl_o), 0);
        @(negedge clk);
        run_en = 1'b0;
        @(negedge clk);
        check(scl_o == 1'b1, "R1 release after drop in low", int'(scl_o), 1);
        bad = 0;
        repeat (50) begin
            @(negedge clk);
            if (!scl_o || sda_change || low_start || high_start) bad++;
        end
        check(bad == 0, "R1 no activity while disabled", bad, 0);

        // R1: reset during a run releases SCL
        run_en = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(scl_o == 1'b1, "R1 release on reset mid-run", int'(scl_o), 1);
        rst = 1'b0;
        run_en = 1'b0;
        @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule